// File: doc/BRIEF.md
# Contiguous Translation Entry Allocator

The allocator maps a byte range onto consecutive entries of a translation table. A caller supplies a pool code, a port number, a target start address, a byte length and an MSI flag. The block works out how many pages the range touches. It then walks the slice of table that belongs to that pool, one entry per cycle, looking for the lowest-indexed run of free entries that is long enough. It claims that run by writing valid entries whose page bases rise by one page per entry, and returns the bus address at which the caller's first byte appears.

Two valid-bit tables are held inside. A shared table serves two pools. Its low entries are set aside for very large pages, split evenly between two ports. Its upper entries serve ordinary 32-bit paging. A separate wide table serves 40-bit mapping with medium pages. Each entry write also appears on a write port so that the real table can be kept in step. A release command clears a run of entries in either table, one per cycle, with the same write port. The block is busy from the cycle a command is taken until that command completes.

Top module: `xlat_run_alloc`

## Requirements
- R1: The entry count of a request is (end page index) minus (start page index) plus one, where end = start + length − 1 and the page index is the address shifted right by the pool's page shift; length is at least 1.
- R2: A request whose entry count exceeds its pool's size fails at once, with no entry written.
- R3: Pool code 0 (paged) searches shared-table entries 64 to 127, uses 256 KB pages (shift 18) and has window base 0.
- R4: Pool code 2 (super) searches 32 shared-table entries starting at port × 32, uses 16 GB pages (shift 34) and has window base 2^39.
- R5: Pool code 1 (wide) searches all 64 entries of the wide table, uses 64 MB pages (shift 26) and has window base 2^38.
- R6: The claimed run starts at the lowest index in the slice whose entries are all free. The highest start tried is first + size − count. If no start fits, the request fails.
- R7: An MSI request fails unless the pool is paged. Pool code 3 always fails.
- R8: A claimed entry is written with bit 49 = valid (1), bit 48 = MSI flag and bits 47:0 = page-aligned start address plus k pages, for the k-th entry of the run. The writes go out in ascending index order, one per cycle.
- R9: A successful response carries window base + start index × page size + (start address modulo page size). The index is absolute within its table.
- R10: busy_o rises in the cycle after a command is accepted. Requests that arrive while busy are ignored. busy_o falls after the response or after the last clear.
- R11: A release of count n at index i in the selected table writes zero to entries i to i+n−1 in ascending order, one per cycle, and frees them for later requests. A count of 0 does nothing.
- R12: Each request ends with a single-cycle resp_valid_o that carries resp_ok_o. A failed response carries address 0. When release and request arrive together, the release is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Allocation request strobe |
| req_pool_i | input | 2 | Pool code: 0 paged, 1 wide, 2 super, 3 none |
| req_port_i | input | 1 | Port selecting the super-page slice |
| req_msi_i | input | 1 | Request MSI entries |
| req_addr_i | input | ADDR_W | Target start address |
| req_len_i | input | LEN_W | Byte length, at least 1 |
| rel_valid_i | input | 1 | Release strobe |
| rel_wide_i | input | 1 | Release targets the wide table |
| rel_idx_i | input | IDX_W | First entry to clear |
| rel_cnt_i | input | IDX_W+1 | Number of entries to clear |
| busy_o | output | 1 | Command in progress |
| wr_valid_o | output | 1 | Entry write this cycle |
| wr_wide_o | output | 1 | Write targets the wide table |
| wr_idx_o | output | IDX_W | Entry index written |
| wr_data_o | output | ADDR_W+2 | Entry value written |
| resp_valid_o | output | 1 | Allocation response strobe |
| resp_ok_o | output | 1 | Allocation succeeded |
| resp_addr_o | output | ADDR_W | Mapped bus address |

## Verification
The assertions check on every cycle that each claimed entry is free when written and lies inside its pool's slice. They also check that successive claim writes advance by exactly one page, that an MSI bit appears only in paged-pool entries, that busy rises only after a command strobe, and that the response lasts one cycle. Only the bench scenarios can show the first-fit choice against a model of occupancy, the exact page counts across page boundaries, the returned addresses in each window, the rejections, and reuse of entries freed by release.

// File: rtl/xlat_alloc_pkg.sv
package xlat_alloc_pkg;
  typedef enum logic [1:0] {
    POOL_PAGED = 2'd0,
    POOL_WIDE  = 2'd1,
    POOL_SUPER = 2'd2,
    POOL_NONE  = 2'd3
  } pool_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_CLAIM,
    ST_RESP,
    ST_CLEAR
  } st_e;
endpackage

// File: rtl/xlat_pool_cfg.sv
module xlat_pool_cfg import xlat_alloc_pkg::*; #(
  parameter int ADDR_W         = 48,
  parameter int CNT_W          = 8,
  parameter int SHARED_N       = 128,
  parameter int SUPER_N        = 32,
  parameter int WIDE_N         = 64,
  parameter int PAGED_SHIFT    = 18,
  parameter int WIDE_SHIFT     = 26,
  parameter int SUPER_SHIFT    = 34,
  parameter int WIDE_BASE_BIT  = 38,
  parameter int SUPER_BASE_BIT = 39
) (
  input  pool_e              pool_i,
  input  logic               port_i,
  input  logic               msi_i,
  output logic [CNT_W-1:0]   first_o,
  output logic [CNT_W-1:0]   size_o,
  output logic [5:0]         shift_o,
  output logic [ADDR_W-1:0]  base_o,
  output logic               wide_o,
  output logic               legal_o
);
  localparam int RSV_N = 2 * SUPER_N;

  always_comb begin
    first_o = '0;
    size_o  = '0;
    shift_o = '0;
    base_o  = '0;
    wide_o  = 1'b0;
    legal_o = 1'b0;
    unique case (pool_i)
      POOL_PAGED: begin
        first_o = CNT_W'(RSV_N);
        size_o  = CNT_W'(SHARED_N - RSV_N);
        shift_o = 6'(PAGED_SHIFT);
        legal_o = 1'b1;
      end
      POOL_WIDE: begin
        size_o  = CNT_W'(WIDE_N);
        shift_o = 6'(WIDE_SHIFT);
        base_o  = ADDR_W'(1) << WIDE_BASE_BIT;
        wide_o  = 1'b1;
        legal_o = !msi_i;
      end
      POOL_SUPER: begin
        first_o = port_i ? CNT_W'(SUPER_N) : '0;
        size_o  = CNT_W'(SUPER_N);
        shift_o = 6'(SUPER_SHIFT);
        base_o  = ADDR_W'(1) << SUPER_BASE_BIT;
        legal_o = !msi_i;
      end
      default: legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/xlat_span.sv
module xlat_span #(
  parameter int ADDR_W = 48,
  parameter int LEN_W  = 40
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [5:0]        shift_i,
  output logic [ADDR_W:0]   need_o
);
  localparam int XW = ADDR_W + 1;
  logic [XW-1:0] lo_a, hi_a;

  always_comb begin
    lo_a   = {1'b0, addr_i};
    hi_a   = lo_a + XW'(len_i) - XW'(1);
    need_o = (hi_a >> shift_i) - (lo_a >> shift_i) + XW'(1);
  end
endmodule

// File: rtl/xlat_vtab.sv
module xlat_vtab #(
  parameter int N     = 64,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic             val_i,
  output logic             rd_o
);
  localparam int LW = (N > 1) ? $clog2(N) : 1;
  logic [N-1:0] bits_q;
  logic         in_rng;

  assign in_rng = idx_i < CNT_W'(N);
  assign rd_o   = in_rng ? bits_q[idx_i[LW-1:0]] : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              bits_q <= '0;
    else if (we_i && in_rng)  bits_q[idx_i[LW-1:0]] <= val_i;
  end
endmodule

// File: rtl/xlat_run_alloc.sv
module xlat_run_alloc import xlat_alloc_pkg::*; #(
  parameter int ADDR_W         = 48,
  parameter int LEN_W          = 40,
  parameter int SHARED_N       = 128,
  parameter int SUPER_N        = 32,
  parameter int WIDE_N         = 64,
  parameter int PAGED_SHIFT    = 18,
  parameter int WIDE_SHIFT     = 26,
  parameter int SUPER_SHIFT    = 34,
  parameter int WIDE_BASE_BIT  = 38,
  parameter int SUPER_BASE_BIT = 39,
  localparam int IDX_W = $clog2((SHARED_N > WIDE_N) ? SHARED_N : WIDE_N),
  localparam int CNT_W = IDX_W + 1,
  localparam int ENT_W = ADDR_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_pool_i,
  input  logic              req_port_i,
  input  logic              req_msi_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              rel_valid_i,
  input  logic              rel_wide_i,
  input  logic [IDX_W-1:0]  rel_idx_i,
  input  logic [CNT_W-1:0]  rel_cnt_i,
  output logic              busy_o,
  output logic              wr_valid_o,
  output logic              wr_wide_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [ENT_W-1:0]  wr_data_o,
  output logic              resp_valid_o,
  output logic              resp_ok_o,
  output logic [ADDR_W-1:0] resp_addr_o
);
  localparam int XW = ADDR_W + 1;

  st_e               st_q;
  pool_e             pool_q;
  logic              msi_q, wide_q, ok_q;
  logic [ADDR_W-1:0] addr_q, base_q;
  logic [5:0]        shift_q;
  logic [CNT_W-1:0]  first_q, size_q, last_q, need_q, pos_q, cand_q, run_q, k_q;

  logic [CNT_W-1:0]  c_first, c_size;
  logic [5:0]        c_shift;
  logic [ADDR_W-1:0] c_base;
  logic              c_wide, c_legal, too_big;
  logic [XW-1:0]     need_full;
  logic [CNT_W-1:0]  cur_idx;
  logic              sh_rd, wd_rd, v_rd;
  logic [ADDR_W-1:0] pg_mask;

  xlat_pool_cfg #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SHARED_N(SHARED_N), .SUPER_N(SUPER_N),
    .WIDE_N(WIDE_N), .PAGED_SHIFT(PAGED_SHIFT), .WIDE_SHIFT(WIDE_SHIFT),
    .SUPER_SHIFT(SUPER_SHIFT), .WIDE_BASE_BIT(WIDE_BASE_BIT),
    .SUPER_BASE_BIT(SUPER_BASE_BIT)
  ) u_cfg (
    .pool_i(pool_e'(req_pool_i)), .port_i(req_port_i), .msi_i(req_msi_i),
    .first_o(c_first), .size_o(c_size), .shift_o(c_shift), .base_o(c_base),
    .wide_o(c_wide), .legal_o(c_legal)
  );

  // count is computed from the raw request, using the pool's shift
  xlat_span #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_span (
    .addr_i(req_addr_i), .len_i(req_len_i), .shift_i(c_shift), .need_o(need_full)
  );

  assign too_big = need_full > XW'(c_size);
  assign cur_idx = (st_q == ST_CLAIM) ? cand_q + k_q : pos_q;
  assign pg_mask = (ADDR_W'(1) << shift_q) - ADDR_W'(1);

  assign busy_o       = st_q != ST_IDLE;
  assign wr_valid_o   = (st_q == ST_CLAIM) || (st_q == ST_CLEAR);
  assign wr_wide_o    = wide_q;
  assign wr_idx_o     = cur_idx[IDX_W-1:0];
  assign wr_data_o    = (st_q == ST_CLAIM) ?
                        {1'b1, msi_q, (addr_q & ~pg_mask) + (ADDR_W'(k_q) << shift_q)} : '0;
  assign resp_valid_o = st_q == ST_RESP;
  assign resp_ok_o    = resp_valid_o && ok_q;
  assign resp_addr_o  = resp_ok_o ?
                        base_q + (ADDR_W'(cand_q) << shift_q) + (addr_q & pg_mask) : '0;

  xlat_vtab #(.N(SHARED_N), .CNT_W(CNT_W)) u_sh_tab (
    .clk_i, .rst_ni, .we_i(wr_valid_o && !wide_q), .idx_i(cur_idx),
    .val_i(st_q == ST_CLAIM), .rd_o(sh_rd)
  );
  xlat_vtab #(.N(WIDE_N), .CNT_W(CNT_W)) u_wd_tab (
    .clk_i, .rst_ni, .we_i(wr_valid_o && wide_q), .idx_i(cur_idx),
    .val_i(st_q == ST_CLAIM), .rd_o(wd_rd)
  );
  assign v_rd = wide_q ? wd_rd : sh_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      pool_q  <= POOL_NONE;
      msi_q   <= 1'b0;
      wide_q  <= 1'b0;
      ok_q    <= 1'b0;
      addr_q  <= '0;
      base_q  <= '0;
      shift_q <= '0;
      first_q <= '0;
      size_q  <= '0;
      last_q  <= '0;
      need_q  <= '0;
      pos_q   <= '0;
      cand_q  <= '0;
      run_q   <= '0;
      k_q     <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (rel_valid_i) begin
            if (rel_cnt_i != '0) begin
              st_q   <= ST_CLEAR;
              wide_q <= rel_wide_i;
              pos_q  <= CNT_W'(rel_idx_i);
              k_q    <= rel_cnt_i;
            end
          end else if (req_valid_i) begin
            pool_q  <= pool_e'(req_pool_i);
            msi_q   <= req_msi_i;
            addr_q  <= req_addr_i;
            base_q  <= c_base;
            shift_q <= c_shift;
            wide_q  <= c_wide;
            first_q <= c_first;
            size_q  <= c_size;
            ok_q    <= 1'b0;
            cand_q  <= c_first;
            pos_q   <= c_first;
            run_q   <= '0;
            if (!c_legal || too_big) begin
              st_q <= ST_RESP;
            end else begin
              need_q <= need_full[CNT_W-1:0];
              last_q <= c_first + c_size - need_full[CNT_W-1:0];
              st_q   <= ST_SCAN;
            end
          end
        end
        ST_SCAN: begin
          if (v_rd) begin
            if (pos_q >= last_q) st_q <= ST_RESP;
            else begin
              cand_q <= pos_q + 1'b1;
              pos_q  <= pos_q + 1'b1;
              run_q  <= '0;
            end
          end else if (run_q + 1'b1 == need_q) begin
            k_q  <= '0;
            st_q <= ST_CLAIM;
          end else begin
            run_q <= run_q + 1'b1;
            pos_q <= pos_q + 1'b1;
          end
        end
        ST_CLAIM: begin
          k_q <= k_q + 1'b1;
          if (k_q + 1'b1 == need_q) begin
            ok_q <= 1'b1;
            st_q <= ST_RESP;
          end
        end
        ST_RESP: st_q <= ST_IDLE;
        ST_CLEAR: begin
          pos_q <= pos_q + 1'b1;
          k_q   <= k_q - 1'b1;
          if (k_q == CNT_W'(1)) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_claim_free_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CLAIM) |-> !v_rd);
  // slice bounds cover R3, R4 and R5
  assert_claim_slice_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CLAIM) |-> (cur_idx >= first_q && cur_idx < first_q + size_q));
  assert_claim_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CLAIM && $past(st_q) == ST_CLAIM) |->
    (wr_data_o[ADDR_W-1:0] == $past(wr_data_o[ADDR_W-1:0]) + (ADDR_W'(1) << shift_q)));
  assert_msi_pool_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && wr_data_o[ADDR_W]) |-> (pool_q == POOL_PAGED));
  assert_busy_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i || rel_valid_i));
  assert_resp_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o);
endmodule

// File: tb/tb_xlat_run_alloc.sv
module tb_xlat_run_alloc;
  localparam int CLK_PERIOD = 10;
  localparam int SH_N = 128, WD_N = 64, SUP_N = 32;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_valid_i = 0, req_port_i = 0, req_msi_i = 0;
  logic [1:0]  req_pool_i = 0;
  logic [47:0] req_addr_i = 0;
  logic [39:0] req_len_i = 0;
  logic        rel_valid_i = 0, rel_wide_i = 0;
  logic [6:0]  rel_idx_i = 0;
  logic [7:0]  rel_cnt_i = 0;
  logic        busy_o, wr_valid_o, wr_wide_o, resp_valid_o, resp_ok_o;
  logic [6:0]  wr_idx_o;
  logic [49:0] wr_data_o;
  logic [47:0] resp_addr_o;

  int tests = 0, fails = 0;
  bit sh_m[SH_N];
  bit wd_m[WD_N];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  xlat_run_alloc dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int fit(bit wide, int first, int size, int n);
    for (int i = first; i <= first + size - n; i++) begin
      bit all_free = 1;
      for (int j = i; j < i + n; j++)
        if (wide ? wd_m[j] : sh_m[j]) all_free = 0;
      if (all_free) return i;
    end
    return -1;
  endfunction

  task automatic do_alloc(input logic [1:0] pool, input bit port, input bit msi,
                          input logic [47:0] start, input logic [39:0] len,
                          input string req, input bit hold);
    int first, size, sh, idx, k, c;
    bit wide_t, legal, got;
    logic [47:0] base, mask, exp_addr;
    logic [63:0] n;
    logic [49:0] exp_d;
    first = 0; size = 0; sh = 18; base = 0; wide_t = 0; legal = 0;
    case (pool)
      2'd0: begin first = 2*SUP_N; size = SH_N - 2*SUP_N; sh = 18; legal = 1; end
      2'd1: begin size = WD_N; sh = 26; base = 48'h1 << 38; wide_t = 1; legal = !msi; end
      2'd2: begin first = port ? SUP_N : 0; size = SUP_N; sh = 34;
                  base = 48'h1 << 39; legal = !msi; end
      default: legal = 0;
    endcase
    n = ((64'(start) + 64'(len) - 1) >> sh) - (64'(start) >> sh) + 1;
    idx = -1;
    if (legal && n <= 64'(size)) idx = fit(wide_t, first, size, int'(n));
    mask = (48'h1 << sh) - 1;
    exp_addr = (idx >= 0) ? base + (48'(idx) << sh) + (start & mask) : '0;

    @(negedge clk_i);
    req_pool_i = pool; req_port_i = port; req_msi_i = msi;
    req_addr_i = start; req_len_i = len; req_valid_i = 1;
    @(negedge clk_i);
    if (!hold) req_valid_i = 0;
    else req_addr_i = start ^ 48'h4000_0000;
    chk(busy_o == 1'b1, "R10", "busy after accept", 64'(busy_o), 1);
    k = 0; got = 0; c = 0;
    while (!got && c < 400) begin
      if (c == 1) req_valid_i = 0;
      if (wr_valid_o) begin
        exp_d = {1'b1, msi, (start & ~mask) + (48'(k) << sh)};
        chk(32'(wr_idx_o) == idx + k && wr_wide_o == wide_t, req, "claim index",
            64'(wr_idx_o), 64'(idx + k));
        chk(wr_data_o == exp_d, "R8", "entry value", 64'(wr_data_o), 64'(exp_d));
        k++;
      end
      if (resp_valid_o) begin
        got = 1;
        chk(resp_ok_o == (idx >= 0), req, "resp ok", 64'(resp_ok_o), 64'(idx >= 0));
        chk(resp_addr_o == exp_addr, "R9", "resp addr", 64'(resp_addr_o), 64'(exp_addr));
        chk(k == ((idx >= 0) ? int'(n) : 0), "R1", "entries written", 64'(k),
            (idx >= 0) ? n : 64'd0);
      end else begin
        @(negedge clk_i);
        c++;
      end
    end
    req_valid_i = 0;
    chk(got, "R12", "response seen", 64'(got), 1);
    if (idx >= 0)
      for (int j = idx; j < idx + int'(n); j++)
        if (wide_t) wd_m[j] = 1; else sh_m[j] = 1;
    if (hold)
      repeat (3) begin
        @(negedge clk_i);
        chk(!resp_valid_o && !wr_valid_o && !busy_o, "R10", "request while busy ignored",
            {61'd0, resp_valid_o, wr_valid_o, busy_o}, 0);
      end
  endtask

  task automatic do_release(input bit wide, input int idx, input int cnt, input string req);
    int k;
    @(negedge clk_i);
    rel_wide_i = wide; rel_idx_i = 7'(idx); rel_cnt_i = 8'(cnt); rel_valid_i = 1;
    @(negedge clk_i);
    rel_valid_i = 0;
    k = 0;
    while (busy_o && k < 300) begin
      chk(wr_valid_o && 32'(wr_idx_o) == idx + k && wr_data_o == '0 && wr_wide_o == wide,
          req, "clear write", 64'(wr_idx_o), 64'(idx + k));
      k++;
      @(negedge clk_i);
    end
    chk(k == cnt, req, "clear count", 64'(k), 64'(cnt));
    for (int j = idx; j < idx + cnt; j++)
      if (wide) wd_m[j] = 0; else sh_m[j] = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog R12 actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !wr_valid_o && !resp_valid_o, "R10", "reset state",
        {61'd0, busy_o, wr_valid_o, resp_valid_o}, 0);
    rst_ni = 1;

    do_alloc(2'd0, 0, 0, 48'h1234_5678, 40'h100, "R3", 0);
    do_alloc(2'd0, 0, 0, 48'h3_FFFF, 40'h2, "R1", 0);
    do_alloc(2'd1, 0, 0, 48'h800_0000, 40'hC00_0000, "R5", 0);
    do_alloc(2'd2, 1, 0, 48'h4_0000_0123, 40'h10, "R4", 0);
    do_alloc(2'd2, 0, 0, 48'h7_FFFF_FFF0, 40'h20, "R4", 0);
    do_alloc(2'd1, 0, 1, 48'h0, 40'h10, "R7", 0);
    do_alloc(2'd2, 0, 1, 48'h0, 40'h10, "R7", 0);
    do_alloc(2'd3, 0, 0, 48'h0, 40'h10, "R7", 0);
    do_alloc(2'd0, 0, 1, 48'hABC_DEF0, 40'h5_0000, "R7", 0);
    do_alloc(2'd1, 0, 0, 48'h0, 40'h10_4000_0000, "R2", 0);
    do_alloc(2'd0, 0, 0, 48'h0, 40'h104_0000, "R2", 0);
    do_release(1, 1, 1, "R11");
    do_alloc(2'd1, 0, 0, 48'h1000_0000, 40'h100, "R6", 0);
    do_alloc(2'd1, 0, 0, 48'h2000_0000, 40'h400_0001, "R6", 0);
    do_alloc(2'd1, 0, 0, 48'h0, 40'hEC_0000_0000, "R6", 0);
    do_alloc(2'd1, 0, 0, 48'h0, 40'h1, "R6", 0);
    do_release(1, 0, 64, "R11");
    do_release(0, 3, 0, "R11");
    do_alloc(2'd0, 0, 0, 48'h55_0000, 40'h8_0000, "R10", 1);

    for (int op = 0; op < 160; op++) begin
      int r;
      r = int'($urandom % 8);
      if (op % 40 == 39) begin
        do_release(0, 0, SH_N, "R11");
        do_release(1, 0, WD_N, "R11");
      end else if (r < 6) begin
        logic [1:0]  pl;
        logic [63:0] pg, ln;
        logic [47:0] st;
        pl = ($urandom % 10 == 0) ? 2'd3 : 2'($urandom % 3);
        pg = (pl == 2'd1) ? 64'h1 << 26 : (pl == 2'd2) ? 64'h1 << 34 : 64'h1 << 18;
        ln = 1 + ({$urandom, $urandom} % (pg * (1 + $urandom % 4)));
        st = {$urandom, $urandom} & 48'h0FFF_FFFF_FFFF;
        do_alloc(pl, 1'($urandom), ($urandom % 5 == 0), st, 40'(ln), "R6", 0);
      end else begin
        bit w;
        int ix, cn;
        w  = 1'($urandom);
        ix = int'($urandom % (w ? WD_N : SH_N));
        cn = 1 + int'($urandom % 6);
        if (ix + cn > (w ? WD_N : SH_N)) cn = (w ? WD_N : SH_N) - ix;
        do_release(w, ix, cn, "R11");
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule